// File: doc/BRIEF.md
# Per-Core Countdown Interrupt Timer

This block is a per-core down-counting timer that software reaches through a small 32-bit register window. Software chooses a clock divide ratio, fills in a timer entry (interrupt vector, mask, mode) and then writes a start count. That write loads the live counter and starts it. The counter steps down once per divided clock. When it expires, the block raises an interrupt request that carries the programmed vector and holds it until the core acknowledges it.

The timer has two modes. A one-shot timer fires once and rests at zero. A periodic timer reloads from the start count and keeps firing at a fixed interval. A global software-enable bit in the spurious-vector register gates delivery for the whole block. The live count can be read at any time, for example to calibrate the bus clock against an external time source.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), the spurious-vector register reads 0x0000_00FF (software enable clear), the divide register reads 0, both counts read 0 and `irq_req` is low.
- R2: A write to offset 0x380 stores the start count, loads the same value into the live counter and restarts the prescaler phase. The live count at offset 0x390 then reads the written value.
- R3: The divide code is formed from write-data bits {3,1,0}. Codes 0 to 6 divide by 2, 4, 8, 16, 32, 64, 128, and code 7 divides by 1. Bit 2 is ignored and reads back as 0. The live counter drops by one every R clocks, where R is the selected ratio.
- R4: In one-shot mode (timer entry bit 17 = 0), a start count N makes the counter expire exactly N·R clocks after the loading write. The live count then stays at 0 and does not fire again.
- R5: In periodic mode (timer entry bit 17 = 1), the counter reloads from the start count on each expiry and fires every N·R clocks.
- R6: An expiry raises a request only when the timer entry mask bit 16 is 0 and the software-enable bit 8 at offset 0x0F0 is 1. Otherwise the expiry is dropped.
- R7: `irq_req` stays high and `irq_vec` holds timer entry bits [7:0] from the expiry until a one-cycle `irq_ack` clears it. If a new delivery lands in the same cycle as the acknowledge, the request stays set.
- R8: Writing a start count of 0 stops the timer, leaves the live count at 0 and raises no request.
- R9: A write to the divide register at offset 0x3E0 restarts the prescaler phase, with no counter step in that cycle, and leaves the live count unchanged.
- R10: The live-count register is read-only. Writes to it are ignored, unused bits read as 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle `rd_en` is high |
| irq_req | output | 1 | Pending timer interrupt request |
| irq_vec | output | 8 | Vector carried with the request |
| irq_ack | input | 1 | One-cycle acknowledge of the request |

## Verification
The bench measures the exact number of clocks from the loading write to the request, under random ratios and counts. A prescaler that is off by one, or a counter that fires one step early, shows up as a wrong interval. A second divide write in the middle of a count exposes a design that keeps the old prescaler phase or takes a step on the rewrite: the live count reads back one lower, or the expiry comes a few clocks early. Masked, disabled and zero-count runs catch a design that leaks requests, and periodic runs catch a missing reload. Holding the request without an acknowledge catches a request that self-clears or a vector that drifts.

// File: rtl/ctt_pkg.sv
`timescale 1ns/1ps
package ctt_pkg;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned PRE_W    = 7;

  localparam logic [11:0] OFS_SPUR = 12'h0F0;
  localparam logic [11:0] OFS_LVT  = 12'h320;
  localparam logic [11:0] OFS_INIT = 12'h380;
  localparam logic [11:0] OFS_CUR  = 12'h390;
  localparam logic [11:0] OFS_DIV  = 12'h3E0;

  localparam int unsigned ENT_MASK_BIT = 16;
  localparam int unsigned ENT_PER_BIT  = 17;
  localparam int unsigned SPUR_EN_BIT  = 8;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vec;
  } tmr_entry_t;

  // shift amount of the divide ratio for a compressed 3-bit code
  function automatic logic [CODE_W-1:0] ratio_shift(input logic [CODE_W-1:0] code);
    return (code == 3'd7) ? 3'd0 : code + 3'd1;
  endfunction
endpackage

// File: rtl/ctt_regs.sv
`timescale 1ns/1ps
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_cnt,
  output logic [DATA_W-1:0] rdata,
  output tmr_entry_t        entry,
  output logic              sw_en,
  output logic [DATA_W-1:0] init_cnt,
  output logic [CODE_W-1:0] div_code,
  output logic              load,
  output logic              div_wr
);
  logic hit_spur, hit_ent, hit_init, hit_div;

  tmr_entry_t        entry_q, entry_d;
  logic [VEC_W-1:0]  spur_q, spur_d;
  logic              en_q, en_d;
  logic [DATA_W-1:0] init_q, init_d;
  logic [CODE_W-1:0] div_q, div_d;

  always_comb begin
    hit_spur = wr_en && (addr == ADDR_W'(OFS_SPUR));
    hit_ent  = wr_en && (addr == ADDR_W'(OFS_LVT));
    hit_init = wr_en && (addr == ADDR_W'(OFS_INIT));
    hit_div  = wr_en && (addr == ADDR_W'(OFS_DIV));
  end

  always_comb begin
    entry_d = entry_q;
    spur_d  = spur_q;
    en_d    = en_q;
    init_d  = init_q;
    div_d   = div_q;
    if (hit_ent) begin
      entry_d.vec      = wdata[VEC_W-1:0];
      entry_d.masked   = wdata[ENT_MASK_BIT];
      entry_d.periodic = wdata[ENT_PER_BIT];
    end
    if (hit_spur) begin
      spur_d = wdata[VEC_W-1:0];
      en_d   = wdata[SPUR_EN_BIT];
    end
    if (hit_init) init_d = wdata;
    if (hit_div)  div_d  = {wdata[3], wdata[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '{periodic: 1'b0, masked: 1'b1, vec: '0};
      spur_q  <= '1;
      en_q    <= 1'b0;
      init_q  <= '0;
      div_q   <= '0;
    end else begin
      entry_q <= entry_d;
      spur_q  <= spur_d;
      en_q    <= en_d;
      init_q  <= init_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(OFS_LVT):  rdata = DATA_W'({entry_q.periodic, entry_q.masked, 8'h00, entry_q.vec});
        ADDR_W'(OFS_SPUR): rdata = DATA_W'({en_q, spur_q});
        ADDR_W'(OFS_INIT): rdata = init_q;
        ADDR_W'(OFS_CUR):  rdata = cur_cnt;
        ADDR_W'(OFS_DIV):  rdata = DATA_W'({div_q[2], 1'b0, div_q[1:0]});
        default:           rdata = '0;
      endcase
    end
  end

  assign entry    = entry_q;
  assign sw_en    = en_q;
  assign init_cnt = init_q;
  assign div_code = div_q;
  assign load     = hit_init;
  assign div_wr   = hit_div;
endmodule

// File: rtl/ctt_prescale.sv
`timescale 1ns/1ps
module ctt_prescale
  import ctt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [PRE_W-1:0] phase_q, phase_d;
  logic [PRE_W-1:0] limit;
  logic             at_end;

  always_comb begin
    limit  = (PRE_W'(1) << ratio_shift(code)) - PRE_W'(1);
    at_end = (phase_q == limit);
    tick   = run && !restart && at_end;
    if (restart || at_end) phase_d = '0;
    else                   phase_d = phase_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/ctt_count.sv
`timescale 1ns/1ps
module ctt_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
      run_d = |load_val;
    end else if (run_q && tick) begin
      if (cnt_q == CNT_W'(1)) begin
        expire = 1'b1;
        if (periodic) begin
          cnt_d = reload_val;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cur_cnt = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/ctt_irq.sv
`timescale 1ns/1ps
module ctt_irq
  import ctt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             masked,
  input  logic             sw_en,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             ack,
  output logic             deliver,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic             req_q, req_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    deliver = expire && !masked && sw_en;
    req_d   = req_q;
    vec_d   = vec_q;
    if (deliver) begin
      req_d = 1'b1;
      vec_d = vec_in;
    end else if (ack) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
    end
  end

  assign req = req_q;
  assign vec = vec_q;
endmodule

// File: rtl/core_tick_timer.sv
`timescale 1ns/1ps
module core_tick_timer
  import ctt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  logic [1:0]        rst_sync;
  logic              rst_n;
  tmr_entry_t        entry;
  logic              sw_en;
  logic [DATA_W-1:0] init_cnt;
  logic [DATA_W-1:0] cur_cnt;
  logic [CODE_W-1:0] div_code;
  logic              load, div_wr, tick, running, expire, deliver;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  ctt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cur_cnt(cur_cnt), .rdata(rdata), .entry(entry),
    .sw_en(sw_en), .init_cnt(init_cnt), .div_code(div_code),
    .load(load), .div_wr(div_wr)
  );

  ctt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(load || div_wr),
    .code(div_code), .tick(tick)
  );

  ctt_count #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wdata),
    .reload_val(init_cnt), .periodic(entry.periodic), .tick(tick),
    .cur_cnt(cur_cnt), .running(running), .expire(expire)
  );

  ctt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .masked(entry.masked),
    .sw_en(sw_en), .vec_in(entry.vec), .ack(irq_ack), .deliver(deliver),
    .req(irq_req), .vec(irq_vec)
  );
endmodule

// File: rtl/ctt_checker.sv
`timescale 1ns/1ps
module ctt_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [DATA_W-1:0] load_val,
  input logic              tick,
  input logic              running,
  input logic [DATA_W-1:0] cur_cnt,
  input logic              deliver,
  input logic              masked,
  input logic              sw_en,
  input logic              irq_req,
  input logic              irq_ack,
  input logic [7:0]        irq_vec
);
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_cnt == $past(load_val));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && running && tick && cur_cnt > DATA_W'(1)) |=> cur_cnt == $past(cur_cnt) - DATA_W'(1));

  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cur_cnt));

  a_r4_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !running) |=> (!running && $stable(cur_cnt)));

  a_r6_gated_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(sw_en) && !$past(masked)));

  a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);

  a_r7_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !deliver) |=> $stable(irq_vec));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !deliver) |=> !irq_req);

  a_r8_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !running);
endmodule

bind core_tick_timer ctt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_val(wdata), .tick(tick),
  .running(running), .cur_cnt(cur_cnt), .deliver(deliver),
  .masked(entry.masked), .sw_en(sw_en), .irq_req(irq_req),
  .irq_ack(irq_ack), .irq_vec(irq_vec)
);

// File: tb/core_tick_timer_tb.sv
`timescale 1ns/1ps
module core_tick_timer_tb_top;
  logic        clk;
  logic        rst_ni;
  logic        wr_en, rd_en, irq_ack;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int checks;
  int errors;
  longint cyc;
  longint t_wr;

  core_tick_timer dut_i (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ratio_of(input logic [31:0] d);
    logic [2:0] c;
    c = {d[3], d[1:0]};
    return (c == 3'd7) ? 1 : (2 << c);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    t_wr = cyc;
  endtask

  // call at a falling edge: samples the combinational read port
  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output longint dt);
    int n;
    n = 0;
    while (!irq_req && n < limit) begin
      @(negedge clk);
      n++;
    end
    dt = cyc - t_wr;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=0x%0h expected=0x%0h", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    longint dt;
    process::self().srandom(32'h5eed_1234);
    checks = 0; errors = 0;
    wr_en = 0; rd_en = 0; irq_ack = 0; addr = '0; wdata = '0;
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!irq_req, "R1 irq", irq_req, 0);
    bus_rd(12'h320, rd); check(rd == 32'h0001_0000, "R1 entry", rd, 32'h0001_0000);
    bus_rd(12'h0F0, rd); check(rd == 32'h0000_00FF, "R1 spur", rd, 32'h0000_00FF);
    bus_rd(12'h390, rd); check(rd == 0, "R1 cur", rd, 0);
    bus_rd(12'h3E0, rd); check(rd == 0, "R1 div", rd, 0);
    bus_rd(12'h380, rd); check(rd == 0, "R1 init", rd, 0);

    // R10 readback of fields and unmapped offset
    bus_wr(12'h320, 32'hFFFF_FFFF);
    bus_rd(12'h320, rd); check(rd == 32'h0003_00FF, "R10 entry fields", rd, 32'h0003_00FF);
    bus_wr(12'h3E0, 32'h0000_000F);
    bus_rd(12'h3E0, rd); check(rd == 32'h0000_000B, "R3 bit2 dropped", rd, 32'h0000_000B);
    bus_rd(12'h200, rd); check(rd == 0, "R10 unmapped", rd, 0);

    bus_wr(12'h0F0, 32'h0000_01FF);

    // R2/R3 mid-count live value, divide by 2
    bus_wr(12'h320, 32'h0000_0021);
    bus_wr(12'h3E0, 32'h0);
    bus_wr(12'h380, 32'd10);
    bus_rd(12'h390, rd); check(rd == 10, "R2 load value", rd, 10);
    repeat (5) @(negedge clk);
    bus_rd(12'h390, rd); check(rd == 8, "R3 live count", rd, 8);
    wait_irq(100, dt); check(dt == 20, "R4 one-shot interval", dt, 20);
    check(irq_vec == 8'h21, "R7 vector", irq_vec, 8'h21);
    repeat (10) @(negedge clk);
    check(irq_req && irq_vec == 8'h21, "R7 held without ack", irq_req, 1);
    ack_pulse();
    check(!irq_req, "R7 ack clears", irq_req, 0);
    bus_rd(12'h390, rd); check(rd == 0, "R4 rests at zero", rd, 0);
    repeat (60) @(negedge clk);
    check(!irq_req, "R4 no refire", irq_req, 0);

    // R3 bit 2 ignored: code 0x4 behaves as divide by 2
    bus_wr(12'h3E0, 32'h4);
    bus_wr(12'h380, 32'd3);
    wait_irq(100, dt); check(dt == 6, "R3 bit2 ignored timing", dt, 6);
    ack_pulse();

    // R3/R4 random one-shot runs
    for (int i = 0; i < 10; i++) begin
      logic [31:0] dv, n, v;
      longint exp;
      dv = $urandom % 16;
      n  = 1 + ($urandom % 30);
      v  = $urandom % 256;
      bus_wr(12'h320, v);
      bus_wr(12'h3E0, dv);
      bus_wr(12'h380, n);
      exp = longint'(n) * ratio_of(dv);
      wait_irq(5000, dt);
      check(dt == exp, "R3 random interval", dt, exp);
      check(irq_vec == v[7:0], "R7 random vector", irq_vec, v[7:0]);
      ack_pulse();
    end

    // R5 periodic reload
    bus_wr(12'h320, 32'h0002_0040);
    bus_wr(12'h3E0, 32'h0);
    bus_wr(12'h380, 32'd7);
    wait_irq(100, dt); check(dt == 14, "R5 first period", dt, 14);
    ack_pulse();
    wait_irq(100, dt); check(dt == 28, "R5 second period", dt, 28);
    check(irq_vec == 8'h40, "R5 vector", irq_vec, 8'h40);
    ack_pulse();
    bus_wr(12'h380, 32'd0);

    // R8 zero start count
    bus_wr(12'h320, 32'h0000_0011);
    bus_wr(12'h3E0, 32'hB);
    bus_wr(12'h380, 32'd0);
    repeat (40) @(negedge clk);
    check(!irq_req, "R8 no request", irq_req, 0);
    bus_rd(12'h390, rd); check(rd == 0, "R8 count zero", rd, 0);

    // R6 masked entry drops the expiry
    bus_wr(12'h320, 32'h0001_0011);
    bus_wr(12'h380, 32'd5);
    repeat (30) @(negedge clk);
    check(!irq_req, "R6 masked dropped", irq_req, 0);
    bus_rd(12'h390, rd); check(rd == 0, "R6 masked expired", rd, 0);

    // R6 software enable clear drops the expiry
    bus_wr(12'h320, 32'h0000_0011);
    bus_wr(12'h0F0, 32'h0000_00FF);
    bus_wr(12'h380, 32'd5);
    repeat (30) @(negedge clk);
    check(!irq_req, "R6 disabled dropped", irq_req, 0);
    bus_wr(12'h0F0, 32'h0000_01FF);

    // R10 live count is read-only
    bus_wr(12'h3E0, 32'hA);
    bus_wr(12'h380, 32'd1000);
    bus_wr(12'h390, 32'd5);
    bus_rd(12'h390, rd); check(rd == 1000, "R10 read-only count", rd, 1000);
    bus_rd(12'h380, rd); check(rd == 1000, "R10 init readback", rd, 1000);
    bus_wr(12'h380, 32'd0);

    // R9 divide rewrite restarts phase, keeps count
    bus_wr(12'h3E0, 32'h1);
    bus_wr(12'h380, 32'd20);
    repeat (5) @(negedge clk);
    bus_wr(12'h3E0, 32'h1);
    bus_rd(12'h390, rd); check(rd == 19, "R9 count kept", rd, 19);
    wait_irq(500, dt); check(dt == 76, "R9 phase restart", dt, 76);
    ack_pulse();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule